// File: doc/BRIEF.md
# Addressable LED Chain Controller

The block drives a chain of single-wire addressable RGB LEDs. A host loads colour words into an on-chip frame buffer through an SPI slave port. It then issues a refresh command. The block plays the buffer out on its own as a train of timed pulses on one output pin, and no host activity is needed during the frame.

Each pixel is one 24-bit word. The host sends each pixel as three bytes, green then red then blue, and the bytes leave the pin in that same order with the most significant bit first. A one bit is a long high pulse and a zero bit is a short one, both inside a fixed bit period. All three timings are derived from a clock-frequency parameter. After the last pixel the line stays low for a latch gap, and only then may a new frame start.

A pixel-count register sets how many pixels one refresh sends. A test input replaces the buffer with solid colours. It cycles the whole chain through red, green, blue and white frame after frame for as long as the input is held high.

Top module: `led_chain_ctrl`

## Requirements
- R1: After a buffer-write command (byte 0x01, then a 2-byte big-endian pixel address, then colour bytes), every three bytes are stored as one pixel. A refresh transmits each pixel's bytes in the order they were written, most significant bit first.
- R2: A zero bit is high for CLK_HZ/2,500,000 cycles (0.4 us), a one bit is high for CLK_HZ/1,250,000 cycles (0.8 us). Consecutive bits within a frame, including across pixel boundaries, start CLK_HZ/800,000 cycles (1.25 us) apart.
- R3: After the last bit of a frame, the output stays low for at least CLK_HZ/20,000 cycles (50 us) before busy falls.
- R4: The write address starts at the value given in the command and advances by one pixel for every three colour bytes.
- R5: A pixel whose address is at or above 2**PIX_AW is discarded and changes no stored pixel. The write address stops at 0xFFFF instead of wrapping.
- R6: Command 0x03 followed by a 2-byte big-endian value sets the number of pixels sent per refresh. Values above 2**PIX_AW are clamped to 2**PIX_AW. A count of zero sends no bits but still produces the latch gap with busy high.
- R7: Command 0x02 requests a refresh. Busy is high from the start of a frame until its latch gap ends. A request that arrives while busy is held and starts one more frame within two cycles of busy falling, so no request is lost, including one that lands in the cycle the gap ends.
- R8: While the test input is high, frames repeat back to back with every pixel set to solid red (word 0x00FF00), then green (0xFF0000), then blue (0x0000FF), then white (0xFFFFFF), starting from red each time the input is raised.
- R9: Raising chip select ends a transaction: a partly received pixel is discarded. After any command byte other than 0x01, 0x02 or 0x03, the rest of the transaction is ignored.
- R10: After reset the output is low, busy is low and the pixel count is 2**PIX_AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| spiSclk | input | 1 | SPI clock, data sampled on its rising edge (mode 0) |
| spiCsN | input | 1 | SPI chip select, active low |
| spiMosi | input | 1 | SPI data from host, most significant bit first |
| testMode | input | 1 | High selects the repeating solid-colour test sequence |
| ledOut | output | 1 | Single-wire pulse stream to the LED chain |
| busy | output | 1 | High while a frame or its latch gap is in progress |

## Verification
The riskiest coincidence is a refresh command that the SPI parser accepts in the same cycle as the serializer reports the end of a latch gap. A pending flag that is both set and cleared in that cycle, or a start that is missed, would lose the second frame. The bench provokes this by starting a one-pixel frame and then sweeping the arrival of a second refresh command in 4-cycle steps across the window where the gap ends. For every offset it requires exactly two busy pulses and exactly two pixels' worth of correctly timed bits.

// File: rtl/lcc_pkg.sv
package lcc_pkg;

  localparam int PIXEL_BITS = 24;
  localparam int SPI_ADDR_W = 16;

  localparam logic [7:0] CMD_WRITE   = 8'h01;
  localparam logic [7:0] CMD_REFRESH = 8'h02;
  localparam logic [7:0] CMD_COUNT   = 8'h03;

  // Strobes and settings passed from control to datapath
  typedef struct packed {
    logic                  startFrame;
    logic                  useSolid;
    logic [PIXEL_BITS-1:0] solidColor;
    logic [SPI_ADDR_W-1:0] pixCount;
    logic                  wrEn;
    logic [SPI_ADDR_W-1:0] wrAddr;
    logic [PIXEL_BITS-1:0] wrData;
  } ctrlStrobe_t;

  // Test colours in line order: green byte, red byte, blue byte
  function automatic logic [PIXEL_BITS-1:0] testColor(input logic [1:0] idx);
    case (idx)
      2'd0:    testColor = 24'h00FF00;
      2'd1:    testColor = 24'hFF0000;
      2'd2:    testColor = 24'h0000FF;
      default: testColor = 24'hFFFFFF;
    endcase
  endfunction

endpackage

// File: rtl/lcc_spi_rx.sv
module lcc_spi_rx (
  input  logic       clk,
  input  logic       rstN,
  input  logic       spiSclk,
  input  logic       spiCsN,
  input  logic       spiMosi,
  output logic       byteValid,
  output logic [7:0] byteData,
  output logic       selActive
);

  logic [2:0] sclkSync;
  logic [1:0] csSync;
  logic [1:0] mosiSync;
  logic [2:0] bitCnt;
  logic [6:0] shiftQ;
  logic       sclkRise;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkSync <= '0;
      csSync   <= 2'b11;
      mosiSync <= '0;
    end else begin
      sclkSync <= {sclkSync[1:0], spiSclk};
      csSync   <= {csSync[0], spiCsN};
      mosiSync <= {mosiSync[0], spiMosi};
    end
  end

  assign sclkRise  = sclkSync[1] & ~sclkSync[2];
  assign selActive = ~csSync[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt    <= '0;
      shiftQ    <= '0;
      byteValid <= 1'b0;
      byteData  <= '0;
    end else begin
      byteValid <= 1'b0;
      if (!selActive) begin
        bitCnt <= '0;
      end else if (sclkRise) begin
        shiftQ <= {shiftQ[5:0], mosiSync[1]};
        bitCnt <= bitCnt + 3'd1;
        if (bitCnt == 3'd7) begin
          byteValid <= 1'b1;
          byteData  <= {shiftQ, mosiSync[1]};
        end
      end
    end
  end

  // R9
  byte_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |-> $past(selActive));

endmodule

// File: rtl/lcc_ctrl.sv
module lcc_ctrl
  import lcc_pkg::*;
#(
  parameter int PIX_AW = 11
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        byteValid,
  input  logic [7:0]  byteData,
  input  logic        selActive,
  input  logic        testMode,
  input  logic        frameDone,
  output ctrlStrobe_t strb,
  output logic        busy
);

  localparam int MAX_PIX = 1 << PIX_AW;
  localparam logic [SPI_ADDR_W-1:0] MAX16 = SPI_ADDR_W'(MAX_PIX);

  typedef enum logic [2:0] {P_CMD, P_AHI, P_ALO, P_DATA, P_CHI, P_CLO, P_SKIP} pState_t;

  pState_t                pState;
  logic [7:0]             hiByte, byte0, byte1;
  logic [1:0]             byteSel;
  logic [SPI_ADDR_W-1:0]  wrPtr, wrAddrQ, cntReg, rxWord;
  logic [PIXEL_BITS-1:0]  wrDataQ, solidQ;
  logic                   wrEnQ, refreshReq;
  logic                   running, pending, startQ, useSolidQ;
  logic [1:0]             colorIdx;

  assign rxWord = {hiByte, byteData};

  // Command parser
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pState     <= P_CMD;
      hiByte     <= '0;
      byte0      <= '0;
      byte1      <= '0;
      byteSel    <= '0;
      wrPtr      <= '0;
      wrAddrQ    <= '0;
      wrDataQ    <= '0;
      wrEnQ      <= 1'b0;
      refreshReq <= 1'b0;
      cntReg     <= MAX16;
    end else begin
      wrEnQ      <= 1'b0;
      refreshReq <= 1'b0;
      if (!selActive) begin
        pState  <= P_CMD;
        byteSel <= '0;
      end else if (byteValid) begin
        unique case (pState)
          P_CMD: begin
            if (byteData == CMD_WRITE)        pState <= P_AHI;
            else if (byteData == CMD_COUNT)   pState <= P_CHI;
            else begin
              refreshReq <= (byteData == CMD_REFRESH);
              pState     <= P_SKIP;
            end
          end
          P_AHI: begin
            hiByte <= byteData;
            pState <= P_ALO;
          end
          P_ALO: begin
            wrPtr   <= rxWord;
            byteSel <= '0;
            pState  <= P_DATA;
          end
          P_DATA: begin
            if (byteSel == 2'd0) begin
              byte0   <= byteData;
              byteSel <= 2'd1;
            end else if (byteSel == 2'd1) begin
              byte1   <= byteData;
              byteSel <= 2'd2;
            end else begin
              wrEnQ   <= (wrPtr < MAX16);
              wrAddrQ <= wrPtr;
              wrDataQ <= {byte0, byte1, byteData};
              byteSel <= 2'd0;
              if (wrPtr != '1) wrPtr <= wrPtr + 1'b1;
            end
          end
          P_CHI: begin
            hiByte <= byteData;
            pState <= P_CLO;
          end
          P_CLO: begin
            cntReg <= (rxWord > MAX16) ? MAX16 : rxWord;
            pState <= P_SKIP;
          end
          default: ;
        endcase
      end
    end
  end

  // Refresh sequencing
  always_ff @(posedge clk) begin
    if (!rstN) begin
      running   <= 1'b0;
      pending   <= 1'b0;
      startQ    <= 1'b0;
      useSolidQ <= 1'b0;
      solidQ    <= '0;
      colorIdx  <= '0;
    end else begin
      startQ <= 1'b0;
      if (!running) begin
        if (refreshReq || pending || testMode) begin
          startQ    <= 1'b1;
          running   <= 1'b1;
          pending   <= 1'b0;
          useSolidQ <= testMode;
          solidQ    <= testColor(colorIdx);
          if (testMode) colorIdx <= colorIdx + 2'd1;
        end else begin
          colorIdx <= '0;
        end
      end else begin
        if (refreshReq) pending <= 1'b1;
        if (frameDone)  running <= 1'b0;
      end
    end
  end

  assign busy = running;

  always_comb begin
    strb            = '0;
    strb.startFrame = startQ;
    strb.useSolid   = useSolidQ;
    strb.solidColor = solidQ;
    strb.pixCount   = cntReg;
    strb.wrEn       = wrEnQ;
    strb.wrAddr     = wrAddrQ;
    strb.wrData     = wrDataQ;
  end

  // R7
  start_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.startFrame |-> !$past(busy));

  // R7
  done_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> busy);

  // R5
  wr_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn |-> (strb.wrAddr < MAX16));

  // R6
  count_clamp_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.pixCount <= MAX16);

endmodule

// File: rtl/lcc_datapath.sv
module lcc_datapath
  import lcc_pkg::*;
#(
  parameter int PIX_AW = 11,
  parameter int CLK_HZ = 125_000_000
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strb,
  output logic        frameDone,
  output logic        ledOut
);

  localparam int MAX_PIX = 1 << PIX_AW;
  localparam int BIT_CYC = CLK_HZ / 800_000;
  localparam int T0H_CYC = CLK_HZ / 2_500_000;
  localparam int T1H_CYC = CLK_HZ / 1_250_000;
  localparam int GAP_CYC = CLK_HZ / 20_000;
  localparam int TW      = $clog2(GAP_CYC + 1);
  localparam logic [TW-1:0] BIT_LAST = TW'(BIT_CYC - 1);
  localparam logic [TW-1:0] GAP_LAST = TW'(GAP_CYC - 1);
  localparam logic [TW-1:0] T0H_V    = TW'(T0H_CYC);
  localparam logic [TW-1:0] T1H_V    = TW'(T1H_CYC);

  typedef enum logic [2:0] {D_IDLE, D_PRIME, D_LOAD, D_BITS, D_GAP} dState_t;

  dState_t                dState;
  logic [PIXEL_BITS-1:0]  frameMem [MAX_PIX];
  logic [PIXEL_BITS-1:0]  rdWord, shiftQ, solidQ, nextWord;
  logic                   useSolidQ;
  logic [PIX_AW:0]        pixIdx, lastIdx;
  logic [4:0]             bitIdx;
  logic [TW-1:0]          timer, highLen, hiRun;
  logic [PIX_AW-1:0]      rdAddr;

  always_ff @(posedge clk) begin
    if (strb.wrEn) frameMem[strb.wrAddr[PIX_AW-1:0]] <= strb.wrData;
  end

  // Prefetch the following pixel while the current one shifts out
  assign rdAddr = (dState == D_BITS) ? pixIdx[PIX_AW-1:0] + PIX_AW'(1) : '0;

  always_ff @(posedge clk) begin
    rdWord <= frameMem[rdAddr];
  end

  assign nextWord  = useSolidQ ? solidQ : rdWord;
  assign frameDone = (dState == D_GAP) && (timer == GAP_LAST);
  assign highLen   = shiftQ[PIXEL_BITS-1] ? T1H_V : T0H_V;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dState    <= D_IDLE;
      shiftQ    <= '0;
      solidQ    <= '0;
      useSolidQ <= 1'b0;
      pixIdx    <= '0;
      lastIdx   <= '0;
      bitIdx    <= '0;
      timer     <= '0;
      ledOut    <= 1'b0;
    end else begin
      ledOut <= (dState == D_BITS) && (timer < highLen);
      unique case (dState)
        D_IDLE: begin
          if (strb.startFrame) begin
            useSolidQ <= strb.useSolid;
            solidQ    <= strb.solidColor;
            pixIdx    <= '0;
            lastIdx   <= strb.pixCount[PIX_AW:0] - 1'b1;
            timer     <= '0;
            dState    <= (strb.pixCount == '0) ? D_GAP : D_PRIME;
          end
        end
        D_PRIME: dState <= D_LOAD;
        D_LOAD: begin
          shiftQ <= nextWord;
          bitIdx <= '0;
          timer  <= '0;
          dState <= D_BITS;
        end
        D_BITS: begin
          if (timer == BIT_LAST) begin
            timer <= '0;
            if (bitIdx == 5'(PIXEL_BITS - 1)) begin
              if (pixIdx == lastIdx) begin
                dState <= D_GAP;
              end else begin
                pixIdx <= pixIdx + 1'b1;
                shiftQ <= nextWord;
                bitIdx <= '0;
              end
            end else begin
              shiftQ <= {shiftQ[PIXEL_BITS-2:0], 1'b0};
              bitIdx <= bitIdx + 5'd1;
            end
          end else begin
            timer <= timer + 1'b1;
          end
        end
        D_GAP: begin
          if (timer == GAP_LAST) dState <= D_IDLE;
          else                   timer  <= timer + 1'b1;
        end
        default: dState <= D_IDLE;
      endcase
    end
  end

  // Length of the current high run on the output
  always_ff @(posedge clk) begin
    if (!rstN) hiRun <= '0;
    else       hiRun <= ledOut ? hiRun + 1'b1 : '0;
  end

  // R2
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    hiRun <= T1H_V);

  // R3
  gap_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dState == D_GAP) |-> !ledOut);

  // R7
  start_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.startFrame |-> (dState == D_IDLE));

endmodule

// File: rtl/led_chain_ctrl.sv
module led_chain_ctrl
  import lcc_pkg::*;
#(
  parameter int PIX_AW = 11,
  parameter int CLK_HZ = 125_000_000
) (
  input  logic clk,
  input  logic rstN,
  input  logic spiSclk,
  input  logic spiCsN,
  input  logic spiMosi,
  input  logic testMode,
  output logic ledOut,
  output logic busy
);

  ctrlStrobe_t strb;
  logic        byteValid, selActive, frameDone;
  logic [7:0]  byteData;

  lcc_spi_rx u_spi (
    .clk(clk), .rstN(rstN), .spiSclk(spiSclk), .spiCsN(spiCsN), .spiMosi(spiMosi),
    .byteValid(byteValid), .byteData(byteData), .selActive(selActive)
  );

  lcc_ctrl #(.PIX_AW(PIX_AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteData(byteData),
    .selActive(selActive), .testMode(testMode), .frameDone(frameDone),
    .strb(strb), .busy(busy)
  );

  lcc_datapath #(.PIX_AW(PIX_AW), .CLK_HZ(CLK_HZ)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .frameDone(frameDone), .ledOut(ledOut)
  );

endmodule

// File: tb/led_chain_ctrl_bench.sv
`timescale 1ns/1ps
module led_chain_ctrl_bench;

  localparam int PIX_AW  = 3;
  localparam int NPIX    = 1 << PIX_AW;
  localparam int CLK_HZ  = 20_000_000;
  localparam int BIT_CYC = CLK_HZ / 800_000;
  localparam int T0H     = CLK_HZ / 2_500_000;
  localparam int T1H     = CLK_HZ / 1_250_000;
  localparam int GAP     = CLK_HZ / 20_000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic spiSclk = 1'b0, spiCsN = 1'b1, spiMosi = 1'b0, testMode = 1'b0;
  logic ledOut, busy;

  always #4 clk = ~clk;

  led_chain_ctrl #(.PIX_AW(PIX_AW), .CLK_HZ(CLK_HZ)) u_led_chain_ctrl (
    .clk(clk), .rstN(rstN), .spiSclk(spiSclk), .spiCsN(spiCsN), .spiMosi(spiMosi),
    .testMode(testMode), .ledOut(ledOut), .busy(busy)
  );

  int nChecks = 0, nFail = 0;
  logic [23:0] model [NPIX];
  logic [23:0] expPix [NPIX];
  bit   bitsArr [1024];
  int nBits, pulseErr, perErr, busyRises, gapLow, lastBusyHigh, busyHigh;
  int lowRun = 100000, hiCnt = 0, lastHigh = 0;
  logic outPrev = 1'b0, busyPrev = 1'b0;

  // Output monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (busy) busyHigh++;
    if (busy && !busyPrev) busyRises++;
    if (!busy && busyPrev) begin
      gapLow = lowRun;
      lastBusyHigh = busyHigh;
      busyHigh = 0;
    end
    busyPrev = busy;
    if (ledOut) begin
      if (!outPrev) begin
        if (lowRun < 4 * BIT_CYC && lastHigh + lowRun != BIT_CYC) perErr++;
        hiCnt = 0;
      end
      hiCnt++;
      lowRun = 0;
    end else begin
      if (outPrev) begin
        lastHigh = hiCnt;
        if (hiCnt == T0H || hiCnt == T1H) begin
          if (nBits < 1024) bitsArr[nBits] = (hiCnt == T1H);
          nBits++;
        end else pulseErr++;
      end
      lowRun++;
    end
    outPrev = ledOut;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] pcol(input int s);
    pcol = 24'((s * 40503 + 12345) ^ (s << 13));
  endfunction

  task automatic clearMon();
    nBits = 0; pulseErr = 0; perErr = 0; busyRises = 0;
  endtask

  task automatic csLow();
    spiCsN = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic csHigh();
    repeat (4) @(negedge clk);
    spiCsN = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic spiByte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      spiMosi = b[i];
      repeat (4) @(negedge clk);
      spiSclk = 1'b1;
      repeat (4) @(negedge clk);
      spiSclk = 1'b0;
    end
  endtask

  task automatic sendRefresh();
    csLow(); spiByte(8'h02); csHigh();
  endtask

  task automatic setCount(input logic [15:0] n);
    csLow(); spiByte(8'h03); spiByte(n[15:8]); spiByte(n[7:0]); csHigh();
  endtask

  task automatic writePixels(input int addr, input int n, input int seed);
    logic [23:0] c;
    csLow();
    spiByte(8'h01); spiByte(8'(addr >> 8)); spiByte(8'(addr));
    for (int k = 0; k < n; k++) begin
      c = pcol(seed + k);
      spiByte(c[23:16]); spiByte(c[15:8]); spiByte(c[7:0]);
      if (addr + k < NPIX) model[addr + k] = c;
    end
    csHigh();
  endtask

  task automatic waitIdle();
    while (busyRises == 0) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic doFrame();
    clearMon();
    sendRefresh();
    waitIdle();
  endtask

  task automatic checkBits(input string req, input int base, input int nPix);
    int mis = 0;
    for (int p = 0; p < nPix; p++)
      for (int j = 0; j < 24; j++)
        if (bitsArr[base + p * 24 + j] != expPix[p][23 - j]) mis++;
    check(mis == 0, req, "bit mismatches", mis, 0);
  endtask

  task automatic loadModel();
    for (int p = 0; p < NPIX; p++) expPix[p] = model[p];
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finishRun();
  end

  initial begin
    for (int p = 0; p < NPIX; p++) model[p] = '0;
    clearMon();
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R10 reset state
    check(ledOut == 1'b0, "R10", "ledOut after reset", ledOut, 0);
    check(busy == 1'b0, "R10", "busy after reset", busy, 0);

    // R1 full buffer, default count (R10) of all pixels
    writePixels(0, NPIX, 1);
    doFrame();
    check(nBits == NPIX * 24, "R10", "bits with default count", nBits, NPIX * 24);
    loadModel(); checkBits("R1", 0, NPIX);
    check(pulseErr == 0, "R2", "bad high widths", pulseErr, 0);
    check(perErr == 0, "R2", "bad bit periods", perErr, 0);
    check(gapLow >= GAP, "R3", "low cycles before busy fell", gapLow, GAP);
    check(busyRises == 1, "R7", "busy pulses", busyRises, 1);

    // R4 start address and auto-increment; R5 out-of-range writes
    writePixels(5, 3, 50);
    writePixels(NPIX, 1, 90);
    writePixels(16'hFFFF, 2, 95);
    doFrame();
    loadModel(); checkBits("R4", 0, NPIX);
    check(nBits == NPIX * 24, "R5", "bits after ignored writes", nBits, NPIX * 24);
    check(pulseErr == 0 && perErr == 0, "R2", "timing errors", pulseErr + perErr, 0);

    // R9 partial pixel dropped, unknown command ignored
    csLow(); spiByte(8'h01); spiByte(8'h00); spiByte(8'h02);
    spiByte(8'hAA); spiByte(8'h55); csHigh();
    csLow(); spiByte(8'h55); spiByte(8'h02); spiByte(8'h03); spiByte(8'h00); csHigh();
    repeat (20) @(negedge clk);
    check(busy == 1'b0, "R9", "busy after unknown command", busy, 0);
    doFrame();
    loadModel(); checkBits("R9", 0, NPIX);

    // R6 pixel count register
    setCount(16'd3);
    doFrame();
    check(nBits == 72, "R6", "bits with count 3", nBits, 72);
    checkBits("R6", 0, 3);
    setCount(16'd0);
    doFrame();
    check(nBits == 0, "R6", "bits with count 0", nBits, 0);
    check(lastBusyHigh >= GAP, "R6", "busy length with count 0", lastBusyHigh, GAP);
    setCount(16'd100);
    doFrame();
    check(nBits == NPIX * 24, "R6", "bits with clamped count", nBits, NPIX * 24);

    // R7 second refresh swept across the end of the latch gap
    setCount(16'd1);
    for (int d = 1480; d <= 1560; d += 4) begin
      clearMon();
      sendRefresh();
      while (busyRises == 0) @(negedge clk);
      repeat (d) @(negedge clk);
      sendRefresh();
      while (busy) @(negedge clk);
      repeat (3) @(negedge clk);
      if (busy) while (busy) @(negedge clk);
      repeat (4) @(negedge clk);
      check(busyRises == 2, "R7", "frames for two requests", busyRises, 2);
      check(nBits == 48, "R7", "bits for two requests", nBits, 48);
    end

    // R8 test sequence
    setCount(16'd2);
    clearMon();
    testMode = 1'b1;
    while (busyRises < 5) @(negedge clk);
    testMode = 1'b0;
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    for (int f = 0; f < 5; f++) begin
      logic [23:0] c;
      case (f % 4)
        0: c = 24'h00FF00;
        1: c = 24'hFF0000;
        2: c = 24'h0000FF;
        default: c = 24'hFFFFFF;
      endcase
      expPix[0] = c; expPix[1] = c;
      checkBits("R8", f * 48, 2);
    end
    check(nBits == 5 * 48, "R8", "bits in test frames", nBits, 5 * 48);
    check(pulseErr == 0 && perErr == 0, "R2", "timing errors in test mode", pulseErr + perErr, 0);

    // R8 buffer intact after test mode
    setCount(16'(NPIX));
    doFrame();
    loadModel(); checkBits("R8", 0, NPIX);

    finishRun();
  end

endmodule